// File: doc/BRIEF.md
# Three-Stage Power-Good Sequencer

This block drives three active-low power-good outputs for a hot-swap supply path. The outputs assert one after another, in a fixed order, once the pass transistor is fully on. Stage one asserts when the initial timing cycle has finished and two synchronized comparator flags are both true: the gate is close to the supply and the drain is low. Each later stage needs its own enables and must wait until the stage before it has been asserted for longer than one full sequencing delay. A single internal counter measures every delay interval and restarts from zero for each one. It replaces the ramp of an external timing capacitor.

Four conditions clear all three stages at once: supply lockout, undervoltage, an external reset request, and the fault timer reaching its threshold. Each enable also clears the stages that depend on it. Once a cleared stage's conditions come back, it waits a fresh full delay before it asserts again. The overvoltage input has no effect on any output.

The delay length comes from the `cfg_len` input. When that input is zero, a default derived from the clock frequency and a nominal 300 µs is used instead. A status output shows the state of the sequencer.

Top module: `pgood_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pgood_n` is 3'b111 and `seq_state` is 0.
- R2: In state 0 (idle), with no clearing condition present, stage one (`pgood_n[0]`) goes low at the first clock edge that samples `init_done`, `gate_near_sup` and `drain_low` all high, and `seq_state` becomes 1. Stage one is not asserted while `init_done` is low. Once asserted, stage one stays low until a clearing condition from R6 occurs.
- R3: The delay length D is `cfg_len` when that value is non-zero. If `stage2_en` is high throughout, stage two (`pgood_n[1]`) goes low D+1 cycles after stage one goes low. In the last of those cycles `seq_state` is 2.
- R4: While `seq_state` is 2 and `stage2_en` is low, stage two stays high. Stage two goes low at the first edge that samples `stage2_en` high.
- R5: Stage three (`pgood_n[2]`) goes low D+1 cycles after stage two goes low when `stage2_en` and `stage3_en` are both held high, with `seq_state` 4 in the last waiting cycle and 5 afterwards. A stage is never low while the stage before it is high.
- R6: If `supply_lockout`, `under_volt`, `ext_reset` or `fault_timer_hit` is high at an edge, all outputs are 3'b111 and `seq_state` is 0 after that edge. This holds for as long as the condition remains high.
- R7: `stage2_en` sampled low clears stages two and three at that edge. Stage one is kept, and `seq_state` becomes 6.
- R8: `stage3_en` sampled low while stage three is asserted (and `stage2_en` is high) clears only stage three, and `seq_state` becomes 7.
- R9: After a clear by R7 or R8, the cleared stage re-asserts D+1 cycles after the first cycle in which its enables are all high again. Elapsed time is never reused: an enable dropping during the wait restarts the count.
- R10: `over_volt` has no effect on `pgood_n` or `seq_state`.
- R11: The `seq_state` codes are: 0 idle, 1 stage one timing, 2 stage one held, 3 stage two timing, 4 stage two held, 5 all stages on, 6 stage one re-timing after a stage-two clear, 7 stage two re-timing after a stage-three clear.
- R12: When `cfg_len` is 0, D is the default CLK_HZ×DELAY_NS/10⁹ (rounded). With the default parameters this is 75000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Initial timing cycle has completed |
| gate_near_sup | input | 1 | Gate voltage is close to the supply (synchronized flag) |
| drain_low | input | 1 | Drain is below its low threshold (synchronized flag) |
| stage2_en | input | 1 | Enable for stage two; also required for stage three |
| stage3_en | input | 1 | Enable for stage three |
| supply_lockout | input | 1 | Supply undervoltage lockout; clears all stages |
| under_volt | input | 1 | Undervoltage condition; clears all stages |
| ext_reset | input | 1 | External reset request; clears all stages |
| fault_timer_hit | input | 1 | Fault timer at threshold; clears all stages |
| over_volt | input | 1 | Overvoltage flag; has no effect |
| cfg_len | input | CFG_W | Delay length in cycles; 0 selects the default |
| pgood_n | output | 3 | Registered active-low power-good outputs, bit 0 is stage one |
| seq_state | output | 3 | Current sequencer state code |

## Verification
A wrong state register shows up at `seq_state` in the cycle after the edge that should have moved it. A clearing error shows up at `pgood_n` one edge after the offending input, because every clear acts on the next edge. A counter that is off by even one cycle, or that carries elapsed time across a clear, moves the falling edge of stage two or stage three. The bench therefore samples in the cycle just before and the cycle just after the expected D+1 point, so such a fault is caught exactly at that boundary.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   localparam int unsigned NUM_STAGES = 3;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_S1_RUN   = 3'd1,
      ST_S1_HOLD  = 3'd2,
      ST_S2_RUN   = 3'd3,
      ST_S2_HOLD  = 3'd4,
      ST_S3_ON    = 3'd5,
      ST_S1_REARM = 3'd6,
      ST_S2_REARM = 3'd7
   } seq_st_t;

   // Active-high view of which stages a state asserts; bit 0 = stage one.
   function automatic logic [NUM_STAGES-1:0] stage_mask(input seq_st_t st);
      logic [NUM_STAGES-1:0] m;
      case (st)
         ST_IDLE:                              m = 3'b000;
         ST_S1_RUN, ST_S1_HOLD, ST_S1_REARM:   m = 3'b001;
         ST_S2_RUN, ST_S2_HOLD, ST_S2_REARM:   m = 3'b011;
         ST_S3_ON:                             m = 3'b111;
         default:                              m = 3'b000;
      endcase
      return m;
   endfunction

   // Rounded conversion of a duration in nanoseconds to clock cycles.
   function automatic longint unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned dur_ns);
      return (clk_hz * dur_ns + 64'd500_000_000) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/pgs_delay_timer.sv
module pgs_delay_timer #(
   parameter int unsigned        CFG_W       = 24,
   parameter logic [CFG_W-1:0]   DEF_CYC     = 24'd75000,
   parameter bit                 ALLOW_CFG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [CFG_W-1:0] cfg_len,
   output logic             done
);

   logic [CFG_W-1:0] lim;
   logic [CFG_W-1:0] lim_m1;
   logic [CFG_W-1:0] cnt_q;

   generate
      if (ALLOW_CFG) begin : g_cfg
         assign lim = (cfg_len == '0) ? DEF_CYC : cfg_len;
      end else begin : g_fixed
         logic unused_cfg;
         assign unused_cfg = ^cfg_len;
         assign lim = DEF_CYC;
      end
   endgenerate

   assign lim_m1 = lim - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !run) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = run && (cnt_q >= lim_m1);

   // The counter restarts after every interval boundary
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (clr) |=> (cnt_q == '0)) else $error("counter kept time across a state change"); // R9

endmodule

// File: rtl/pgs_seq_fsm.sv
module pgs_seq_fsm
   import pgs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start_ok,
   input  logic    gclr,
   input  logic    en_s2,
   input  logic    en_s3,
   input  logic    tmr_done,
   output logic    tmr_run,
   output logic    tmr_clr,
   output seq_st_t state_q,
   output seq_st_t state_d
);

   always_comb begin
      state_d = state_q;
      if (gclr) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:     if (start_ok) state_d = ST_S1_RUN;
            ST_S1_RUN:   if (tmr_done) state_d = ST_S1_HOLD;
            ST_S1_REARM: if (tmr_done) state_d = ST_S1_HOLD;
            ST_S1_HOLD:  if (en_s2)    state_d = ST_S2_RUN;
            ST_S2_RUN: begin
               if (!en_s2)        state_d = ST_S1_REARM;
               else if (tmr_done) state_d = ST_S2_HOLD;
            end
            ST_S2_REARM: begin
               if (!en_s2)        state_d = ST_S1_REARM;
               else if (tmr_done) state_d = ST_S2_HOLD;
            end
            ST_S2_HOLD: begin
               if (!en_s2)        state_d = ST_S1_REARM;
               else if (en_s3)    state_d = ST_S3_ON;
            end
            ST_S3_ON: begin
               if (!en_s2)        state_d = ST_S1_REARM;
               else if (!en_s3)   state_d = ST_S2_REARM;
            end
            default:              state_d = ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         ST_S1_RUN, ST_S2_RUN: tmr_run = 1'b1;
         ST_S1_REARM:          tmr_run = en_s2;
         ST_S2_REARM:          tmr_run = en_s2 && en_s3;
         default:              tmr_run = 1'b0;
      endcase
   end

   assign tmr_clr = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   AST_LEAVE_IDLE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) == ST_IDLE) |-> (state_q == ST_S1_RUN && $past(start_ok))) else $error("idle exit without start"); // R2

   AST_S1_HOLD_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S1_HOLD && ($past(state_q) == ST_S1_RUN || $past(state_q) == ST_S1_REARM)) |-> $past(tmr_done)) else $error("stage one held early"); // R3

   AST_S2_HOLD_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S2_HOLD && ($past(state_q) == ST_S2_RUN || $past(state_q) == ST_S2_REARM)) |-> $past(tmr_done)) else $error("stage two held early"); // R5

endmodule

// File: rtl/pgs_out_reg.sv
module pgs_out_reg #(
   parameter int unsigned N          = 3,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] act_d,
   output logic [N-1:0] pin_q
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (ACTIVE_LOW) begin : g_low
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pin_q[i] <= 1'b1;
               else        pin_q[i] <= ~act_d[i];
            end
         end else begin : g_high
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pin_q[i] <= 1'b0;
               else        pin_q[i] <= act_d[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pgood_seq.sv
module pgood_seq
   import pgs_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 250_000_000,
   parameter longint unsigned DELAY_NS  = 300_000,
   parameter int unsigned     CFG_W     = 24,
   parameter bit              ALLOW_CFG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  init_done,
   input  logic                  gate_near_sup,
   input  logic                  drain_low,
   input  logic                  stage2_en,
   input  logic                  stage3_en,
   input  logic                  supply_lockout,
   input  logic                  under_volt,
   input  logic                  ext_reset,
   input  logic                  fault_timer_hit,
   input  logic                  over_volt,
   input  logic [CFG_W-1:0]      cfg_len,
   output logic [NUM_STAGES-1:0] pgood_n,
   output logic [2:0]            seq_state
);

   localparam longint unsigned DEF_CYC_L = ns_to_cycles(CLK_HZ, DELAY_NS);
   localparam longint unsigned CFG_MAX   = (64'd1 << CFG_W) - 64'd1;
   localparam logic [CFG_W-1:0] DEF_CYC  = DEF_CYC_L[CFG_W-1:0];

   generate
      if (CFG_W < 2 || CFG_W > 32) begin : g_bad_w
         $error("CFG_W must lie between 2 and 32");
      end
      if (DEF_CYC_L < 1 || DEF_CYC_L > CFG_MAX) begin : g_bad_def
         $error("default delay does not fit the counter");
      end
   endgenerate

   logic    gclr;
   logic    start_ok;
   logic    tmr_run;
   logic    tmr_clr;
   logic    tmr_done;
   seq_st_t state_q;
   seq_st_t state_d;

   assign gclr     = supply_lockout || under_volt || ext_reset || fault_timer_hit;
   assign start_ok = init_done && gate_near_sup && drain_low;

   pgs_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .gclr     (gclr),
      .en_s2    (stage2_en),
      .en_s3    (stage3_en),
      .tmr_done (tmr_done),
      .tmr_run  (tmr_run),
      .tmr_clr  (tmr_clr),
      .state_q  (state_q),
      .state_d  (state_d)
   );

   pgs_delay_timer #(
      .CFG_W     (CFG_W),
      .DEF_CYC   (DEF_CYC),
      .ALLOW_CFG (ALLOW_CFG)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run),
      .clr     (tmr_clr),
      .cfg_len (cfg_len),
      .done    (tmr_done)
   );

   pgs_out_reg #(
      .N          (NUM_STAGES),
      .ACTIVE_LOW (1'b1)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .act_d (stage_mask(state_d)),
      .pin_q (pgood_n)
   );

   assign seq_state = state_q;

   AST_ORDER_ONE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      !pgood_n[1] |-> !pgood_n[0]) else $error("stage two without stage one"); // R5

   AST_ORDER_TWO_THREE: assert property (@(posedge clk) disable iff (!rst_n)
      !pgood_n[2] |-> !pgood_n[1]) else $error("stage three without stage two"); // R5

   AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      gclr |=> (pgood_n == 3'b111 && seq_state == 3'd0)) else $error("global clear ignored"); // R6

   AST_EN2_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !stage2_en |=> (pgood_n[1] && pgood_n[2])) else $error("stage two held with enable low"); // R7

   AST_EN3_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !stage3_en |=> pgood_n[2]) else $error("stage three held with enable low"); // R8

   AST_OV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (over_volt && !gclr && stage2_en && stage3_en && seq_state == 3'd5) |=> (pgood_n == 3'b000)) else $error("overvoltage disturbed outputs"); // R10

endmodule

// File: tb/pgood_seq_bench.sv
module pgood_seq_bench;

   localparam int unsigned CFG_W   = 24;
   localparam int unsigned D       = 16;
   localparam int unsigned DEF_D   = 75000;
   localparam int unsigned WD_MAX  = 190000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             init_done = 1'b0;
   logic             gate_near_sup = 1'b0;
   logic             drain_low = 1'b0;
   logic             stage2_en = 1'b0;
   logic             stage3_en = 1'b0;
   logic             supply_lockout = 1'b0;
   logic             under_volt = 1'b0;
   logic             ext_reset = 1'b0;
   logic             fault_timer_hit = 1'b0;
   logic             over_volt = 1'b0;
   logic [CFG_W-1:0] cfg_len = CFG_W'(D);
   logic [2:0]       pgood_n;
   logic [2:0]       seq_state;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   pgood_seq u_pgood_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .init_done       (init_done),
      .gate_near_sup   (gate_near_sup),
      .drain_low       (drain_low),
      .stage2_en       (stage2_en),
      .stage3_en       (stage3_en),
      .supply_lockout  (supply_lockout),
      .under_volt      (under_volt),
      .ext_reset       (ext_reset),
      .fault_timer_hit (fault_timer_hit),
      .over_volt       (over_volt),
      .cfg_len         (cfg_len),
      .pgood_n         (pgood_n),
      .seq_state       (seq_state)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WD_MAX) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [2:0] pg, input logic [2:0] st);
      checks++;
      if (pgood_n !== pg || seq_state !== st) begin
         errors++;
         $display("FAIL %s: actual pgood_n=%b state=%0d, expected pgood_n=%b state=%0d",
                  req, pgood_n, seq_state, pg, st);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      init_done = 0; gate_near_sup = 0; drain_low = 0;
      under_volt = 1;
      wait_n(2);
      under_volt = 0;
      wait_n(1);
   endtask

   // Starts stage one and walks to all-on with both enables high (R2, R3, R5).
   task automatic bring_up(input string req);
      stage2_en = 1; stage3_en = 1;
      init_done = 1; gate_near_sup = 1; drain_low = 1;
      wait_n(1);     expect_out({req, " R2 stage one"}, 3'b110, 3'd1);
      wait_n(D);     expect_out({req, " R3 last wait"}, 3'b110, 3'd2);
      wait_n(1);     expect_out({req, " R3 stage two"}, 3'b100, 3'd3);
      wait_n(D);     expect_out({req, " R5 last wait"}, 3'b100, 3'd4);
      wait_n(1);     expect_out({req, " R5 stage three"}, 3'b000, 3'd5);
   endtask

   task automatic t_reset();
      wait_n(2);
      expect_out("R1 in reset", 3'b111, 3'd0);
      rst_n = 1;
      wait_n(1);
      expect_out("R1 after release", 3'b111, 3'd0);
   endtask

   task automatic t_start_gate();
      go_idle();
      gate_near_sup = 1; drain_low = 1; init_done = 0;
      wait_n(3);
      expect_out("R2 no start before init", 3'b111, 3'd0);
      init_done = 1; gate_near_sup = 0;
      wait_n(3);
      expect_out("R2 no start without gate flag", 3'b111, 3'd0);
   endtask

   task automatic t_full_sequence();
      go_idle();
      bring_up("R11 full");
      gate_near_sup = 0; drain_low = 0;
      wait_n(3);
      expect_out("R2 stage one latched", 3'b000, 3'd5);
   endtask

   task automatic t_late_en2();
      go_idle();
      stage2_en = 0; stage3_en = 1;
      init_done = 1; gate_near_sup = 1; drain_low = 1;
      wait_n(D + 6);
      expect_out("R4 waits for enable", 3'b110, 3'd2);
      stage2_en = 1;
      wait_n(1);
      expect_out("R4 asserts on enable", 3'b100, 3'd3);
   endtask

   task automatic t_global_clear();
      for (int src = 0; src < 4; src++) begin
         go_idle();
         bring_up("R6 setup");
         case (src)
            0: supply_lockout = 1;
            1: under_volt = 1;
            2: ext_reset = 1;
            default: fault_timer_hit = 1;
         endcase
         wait_n(1);
         expect_out($sformatf("R6 clear src%0d", src), 3'b111, 3'd0);
         wait_n(4);
         expect_out($sformatf("R6 held src%0d", src), 3'b111, 3'd0);
         supply_lockout = 0; under_volt = 0; ext_reset = 0; fault_timer_hit = 0;
         wait_n(1);
         expect_out($sformatf("R2 restart src%0d", src), 3'b110, 3'd1);
      end
   endtask

   task automatic t_en2_drop();
      go_idle();
      bring_up("R7 setup");
      stage2_en = 0;
      wait_n(1);
      expect_out("R7 en2 low clears two and three", 3'b110, 3'd6);
      wait_n(5);
      expect_out("R7 stays cleared", 3'b110, 3'd6);
      stage2_en = 1;
      wait_n(D - 2);
      stage2_en = 0;
      wait_n(1);
      expect_out("R9 glitch restarts count", 3'b110, 3'd6);
      stage2_en = 1;
      wait_n(D);
      expect_out("R9 fresh delay not yet", 3'b110, 3'd2);
      wait_n(1);
      expect_out("R9 stage two re-asserts", 3'b100, 3'd3);
      wait_n(D + 1);
      expect_out("R9 stage three follows", 3'b000, 3'd5);
   endtask

   task automatic t_en3_drop();
      go_idle();
      bring_up("R8 setup");
      stage3_en = 0;
      wait_n(1);
      expect_out("R8 en3 low clears three only", 3'b100, 3'd7);
      wait_n(3);
      stage3_en = 1;
      wait_n(D);
      expect_out("R9 stage three waits", 3'b100, 3'd4);
      wait_n(1);
      expect_out("R9 stage three re-asserts", 3'b000, 3'd5);
   endtask

   task automatic t_over_volt();
      go_idle();
      over_volt = 1;
      bring_up("R10 ov held");
      for (int k = 0; k < 6; k++) begin
         over_volt = (k % 2 == 0);
         wait_n(1);
         expect_out("R10 toggling ov", 3'b000, 3'd5);
      end
      over_volt = 0;
   endtask

   task automatic t_default_delay();
      go_idle();
      cfg_len = '0;
      stage2_en = 1;
      init_done = 1; gate_near_sup = 1; drain_low = 1;
      wait_n(1);
      expect_out("R12 stage one", 3'b110, 3'd1);
      wait_n(DEF_D);
      expect_out("R12 default last wait", 3'b110, 3'd2);
      wait_n(1);
      expect_out("R12 default stage two", 3'b100, 3'd3);
      cfg_len = CFG_W'(D);
   endtask

   initial begin
      t_reset();
      t_start_gate();
      t_full_sequence();
      t_late_en2();
      t_global_clear();
      t_en2_drop();
      t_en3_drop();
      t_over_volt();
      t_default_delay();
      wait_n(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule